// File: doc/BRIEF.md
# Skewed Banked Matrix Storage

This block holds an 8x8 matrix of data words in eight independent single-port banks of eight flip-flop words each. Element (i,j) is stored in bank i XOR j at word address i. Because of this diagonal skew, every row and every column touches each bank exactly once. A whole row or a whole column can therefore be read, written, or both, in a single cycle without bank conflicts. Two XOR-permuting crossbars convert between bank order and natural element order on the write path and on the read path. Lane k of each slice bus always carries element k of the selected row or column.

A slice operation is selected by an orientation bit, a slice index and read and write enables. A transform datapath outside the block typically issues the eight row slices and then the eight column slices, one per operation. A separate single-element port, addressed by row and column, fills and drains the matrix. This port is locked out in any cycle in which a slice read or slice write is requested.

Top module: `skewed_matrix_store`

## Requirements
- R1: After reset, every one of the 64 elements reads as zero, and both `rd_valid` and `elem_valid` are low.
- R2: A slice read with `slice_col`=0 (row orientation) and index r drives element (r,k) on lane k of `rd_lanes` (bits [k*DATA_W +: DATA_W]) in the cycle after the request, with `rd_valid` high in that cycle only.
- R3: A slice read with `slice_col`=1 (column orientation) and index c drives element (k,c) on lane k of `rd_lanes` in the cycle after the request.
- R4: A slice write in row orientation with index r stores lane k of `wr_lanes` into element (r,k) for all eight k in one clock edge.
- R5: A slice write in column orientation with index c stores lane k of `wr_lanes` into element (k,c) for all eight k in one clock edge.
- R6: A slice read and a slice write issued in the same cycle target the same slice; the read returns the contents before the write, and the new contents appear on the following read.
- R7: An element write with `elem_en`=1, `elem_we`=1 stores `elem_wdata` at element (`elem_row`,`elem_col`), visible to both orientations of slice read.
- R8: An element read with `elem_en`=1, `elem_we`=0 returns element (`elem_row`,`elem_col`) on `elem_rdata` in the next cycle, with `elem_valid` high.
- R9: While `slice_rd` or `slice_wr` is high, the element port is ignored: a write there leaves the element unchanged, and a read there leaves `elem_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears storage and outputs |
| slice_col | input | 1 | Slice orientation: 0 row, 1 column |
| slice_idx | input | IDX_W (3) | Row or column index of the slice |
| slice_rd | input | 1 | Slice read request |
| slice_wr | input | 1 | Slice write request |
| wr_lanes | input | DIM*DATA_W (128) | Write data, lane k = element k of the slice |
| rd_lanes | output | DIM*DATA_W (128) | Registered read data, lane k = element k |
| rd_valid | output | 1 | `rd_lanes` holds data for the previous request |
| elem_en | input | 1 | Single-element access request |
| elem_we | input | 1 | Element access is a write |
| elem_row | input | IDX_W (3) | Element row |
| elem_col | input | IDX_W (3) | Element column |
| elem_wdata | input | DATA_W (16) | Element write data |
| elem_rdata | output | DATA_W (16) | Registered element read data |
| elem_valid | output | 1 | `elem_rdata` holds data for the previous request |

## Verification
The hardest situation to reach is one where the bank mapping is wrong in a self-consistent way. A swapped crossbar selection or address term still returns rows correctly when they are written and read as rows. Therefore every word is written through one path and read through a different one. The stimulus fills elements one by one, then reads them as rows and as columns. It rewrites the matrix as rows and checks it as columns, and rewrites it as columns and checks it as rows and element by element. Each pass uses a value that encodes both coordinates, so any misrouted lane shows up at once. Read-during-write and the element port's lockout are driven in the same cycle as a slice request.

// File: rtl/skew_pkg.sv
package skew_pkg;
   typedef enum logic {
      ORIENT_ROW = 1'b0,
      ORIENT_COL = 1'b1
   } orient_e;
endpackage

// File: rtl/skew_bank.sv
module skew_bank #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
      end else if (we) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/skew_addr_gen.sv
module skew_addr_gen #(
   parameter int DIM   = 8,
   localparam int IDX_W = $clog2(DIM)
) (
   input  skew_pkg::orient_e      orient,
   input  logic [IDX_W-1:0]       idx,
   input  logic                   slice_act,
   input  logic [IDX_W-1:0]       elem_row,
   output logic [DIM*IDX_W-1:0]   bank_addr
);
   for (genvar b = 0; b < DIM; b++) begin : g_bank
      localparam logic [IDX_W-1:0] BID = IDX_W'(b);
      always_comb begin
         if (!slice_act)
            bank_addr[b*IDX_W +: IDX_W] = elem_row;
         else if (orient == skew_pkg::ORIENT_ROW)
            bank_addr[b*IDX_W +: IDX_W] = idx;
         else
            bank_addr[b*IDX_W +: IDX_W] = BID ^ idx;
      end
   end
endmodule

// File: rtl/skew_xbar.sv
module skew_xbar #(
   parameter int DIM    = 8,
   parameter int DATA_W = 16,
   localparam int IDX_W = $clog2(DIM)
) (
   input  logic [IDX_W-1:0]      idx,
   input  logic [DIM*DATA_W-1:0] din,
   output logic [DIM*DATA_W-1:0] dout
);
   for (genvar k = 0; k < DIM; k++) begin : g_lane
      localparam logic [IDX_W-1:0] KID = IDX_W'(k);
      logic [IDX_W-1:0] sel;
      assign sel = KID ^ idx;
      always_comb begin
         dout[k*DATA_W +: DATA_W] = '0;
         for (int s = 0; s < DIM; s++)
            if (sel == IDX_W'(s)) dout[k*DATA_W +: DATA_W] = din[s*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/skewed_matrix_store.sv
module skewed_matrix_store #(
   parameter int DIM    = 8,
   parameter int DATA_W = 16,
   localparam int IDX_W = $clog2(DIM)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  slice_col,
   input  logic [IDX_W-1:0]      slice_idx,
   input  logic                  slice_rd,
   input  logic                  slice_wr,
   input  logic [DIM*DATA_W-1:0] wr_lanes,
   output logic [DIM*DATA_W-1:0] rd_lanes,
   output logic                  rd_valid,
   input  logic                  elem_en,
   input  logic                  elem_we,
   input  logic [IDX_W-1:0]      elem_row,
   input  logic [IDX_W-1:0]      elem_col,
   input  logic [DATA_W-1:0]     elem_wdata,
   output logic [DATA_W-1:0]     elem_rdata,
   output logic                  elem_valid
);
   if (DIM < 2 || (1 << IDX_W) != DIM) begin : g_bad_dim
      $error("skewed_matrix_store: DIM must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("skewed_matrix_store: DATA_W must be positive");
   end

   skew_pkg::orient_e orient;
   logic slice_act, elem_go;
   logic [IDX_W-1:0]      elem_bank;
   logic [DIM*IDX_W-1:0]  bank_addr;
   logic [DIM*DATA_W-1:0] bank_wdata, bank_rdata, rd_aligned;
   logic [DATA_W-1:0]     elem_sel;

   assign orient    = skew_pkg::orient_e'(slice_col);
   assign slice_act = slice_rd | slice_wr;
   assign elem_go   = elem_en & ~slice_act;
   assign elem_bank = elem_row ^ elem_col;

   skew_addr_gen #(.DIM(DIM)) u_addr (
      .orient(orient), .idx(slice_idx), .slice_act(slice_act),
      .elem_row(elem_row), .bank_addr(bank_addr)
   );

   skew_xbar #(.DIM(DIM), .DATA_W(DATA_W)) u_wr_xbar (
      .idx(slice_idx), .din(wr_lanes), .dout(bank_wdata)
   );

   for (genvar b = 0; b < DIM; b++) begin : g_bank
      logic              we_b;
      logic [DATA_W-1:0] wd_b;
      assign we_b = slice_wr | (elem_go & elem_we & (elem_bank == IDX_W'(b)));
      assign wd_b = slice_wr ? bank_wdata[b*DATA_W +: DATA_W] : elem_wdata;
      skew_bank #(.DEPTH(DIM), .DATA_W(DATA_W)) u_bank (
         .clk(clk), .rst_n(rst_n), .we(we_b),
         .addr(bank_addr[b*IDX_W +: IDX_W]), .wdata(wd_b),
         .rdata(bank_rdata[b*DATA_W +: DATA_W])
      );
   end

   skew_xbar #(.DIM(DIM), .DATA_W(DATA_W)) u_rd_xbar (
      .idx(slice_idx), .din(bank_rdata), .dout(rd_aligned)
   );

   always_comb begin
      elem_sel = '0;
      for (int b = 0; b < DIM; b++)
         if (elem_bank == IDX_W'(b)) elem_sel = bank_rdata[b*DATA_W +: DATA_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_lanes   <= '0;
         rd_valid   <= 1'b0;
         elem_rdata <= '0;
         elem_valid <= 1'b0;
      end else begin
         rd_valid   <= slice_rd;
         elem_valid <= elem_go & ~elem_we;
         if (slice_rd) rd_lanes <= rd_aligned;
         if (elem_go & ~elem_we) elem_rdata <= elem_sel;
      end
   end
endmodule

// File: rtl/skewed_matrix_store_chk.sv
module skewed_matrix_store_chk #(
   parameter int DIM    = 8,
   parameter int DATA_W = 16,
   localparam int IDX_W = $clog2(DIM)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  slice_col,
   input logic [IDX_W-1:0]      slice_idx,
   input logic                  slice_rd,
   input logic                  slice_wr,
   input logic [DIM*DATA_W-1:0] wr_lanes,
   input logic [DIM*DATA_W-1:0] rd_lanes,
   input logic                  rd_valid,
   input logic                  elem_en,
   input logic                  elem_we,
   input logic [IDX_W-1:0]      elem_row,
   input logic [IDX_W-1:0]      elem_col,
   input logic [DATA_W-1:0]     elem_wdata,
   input logic [DATA_W-1:0]     elem_rdata,
   input logic                  elem_valid
);
   logic elem_free_rd, elem_free_wr;
   assign elem_free_rd = elem_en & ~elem_we & ~slice_rd & ~slice_wr;
   assign elem_free_wr = elem_en &  elem_we & ~slice_rd & ~slice_wr;

   // R2
   rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slice_rd |=> rd_valid);

   // R2
   rd_valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slice_rd |=> !rd_valid);

   // R4
   slice_wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slice_rd && !slice_wr && $past(slice_wr) &&
       $stable(slice_col) && $stable(slice_idx))
      |=> rd_lanes == $past(wr_lanes, 2));

   // R7
   elem_wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (elem_free_rd && $past(elem_free_wr) &&
       $stable(elem_row) && $stable(elem_col))
      |=> elem_rdata == $past(elem_wdata, 2));

   // R8
   elem_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      elem_free_rd |=> elem_valid);

   // R9
   elem_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slice_rd || slice_wr) |=> !elem_valid);
endmodule

bind skewed_matrix_store skewed_matrix_store_chk #(.DIM(DIM), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .slice_col(slice_col), .slice_idx(slice_idx),
   .slice_rd(slice_rd), .slice_wr(slice_wr), .wr_lanes(wr_lanes),
   .rd_lanes(rd_lanes), .rd_valid(rd_valid), .elem_en(elem_en),
   .elem_we(elem_we), .elem_row(elem_row), .elem_col(elem_col),
   .elem_wdata(elem_wdata), .elem_rdata(elem_rdata), .elem_valid(elem_valid)
);

// File: tb/skewed_matrix_store_tb.sv
module skewed_matrix_store_tb;
   localparam int N = 8;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slice_col = 1'b0;
   logic [2:0] slice_idx = '0;
   logic slice_rd = 1'b0, slice_wr = 1'b0;
   logic [N*W-1:0] wr_lanes = '0;
   logic [N*W-1:0] rd_lanes;
   logic rd_valid;
   logic elem_en = 1'b0, elem_we = 1'b0;
   logic [2:0] elem_row = '0, elem_col = '0;
   logic [W-1:0] elem_wdata = '0;
   logic [W-1:0] elem_rdata;
   logic elem_valid;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [W-1:0] mdl [N][N];

   always #10 clk = ~clk;

   skewed_matrix_store u_dut (
      .clk(clk), .rst_n(rst_n), .slice_col(slice_col), .slice_idx(slice_idx),
      .slice_rd(slice_rd), .slice_wr(slice_wr), .wr_lanes(wr_lanes),
      .rd_lanes(rd_lanes), .rd_valid(rd_valid), .elem_en(elem_en),
      .elem_we(elem_we), .elem_row(elem_row), .elem_col(elem_col),
      .elem_wdata(elem_wdata), .elem_rdata(elem_rdata), .elem_valid(elem_valid)
   );

   function automatic logic [W-1:0] pat(int s, int i, int j);
      return W'((s << 8) | (i << 4) | j);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at a falling edge, check at the next falling edge
   task automatic do_slice(input bit col, input int idx, input bit rd, input bit wr,
                           input logic [N*W-1:0] wbus, input string req);
      logic [N*W-1:0] old;
      for (int k = 0; k < N; k++)
         old[k*W +: W] = col ? mdl[k][idx] : mdl[idx][k];
      slice_col = col; slice_idx = 3'(idx); slice_rd = rd; slice_wr = wr; wr_lanes = wbus;
      @(negedge clk);
      slice_rd = 1'b0; slice_wr = 1'b0;
      if (rd) begin
         chk({req, " rd_valid"}, 32'(rd_valid), 32'd1);
         for (int k = 0; k < N; k++)
            chk(req, 32'(rd_lanes[k*W +: W]), 32'(old[k*W +: W]));
      end
      if (wr)
         for (int k = 0; k < N; k++)
            if (col) mdl[k][idx] = wbus[k*W +: W];
            else     mdl[idx][k] = wbus[k*W +: W];
   endtask

   task automatic do_elem(input bit we, input int r, input int c, input logic [W-1:0] d,
                          input bit blk, input string req);
      elem_en = 1'b1; elem_we = we; elem_row = 3'(r); elem_col = 3'(c); elem_wdata = d;
      slice_rd = blk; slice_col = 1'b0; slice_idx = 3'd0;
      @(negedge clk);
      elem_en = 1'b0; slice_rd = 1'b0;
      chk({req, " rd_valid"}, 32'(rd_valid), 32'(blk));
      if (blk)
         chk({req, " elem_valid blocked"}, 32'(elem_valid), 32'd0);
      else if (!we) begin
         chk({req, " elem_valid"}, 32'(elem_valid), 32'd1);
         chk(req, 32'(elem_rdata), 32'(mdl[r][c]));
      end
      if (we && !blk) mdl[r][c] = d;
   endtask

   function automatic logic [N*W-1:0] slice_bus(int s, bit col, int idx);
      logic [N*W-1:0] v;
      for (int k = 0; k < N; k++)
         v[k*W +: W] = col ? pat(s, k, idx) : pat(s, idx, k);
      return v;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) mdl[i][j] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: outputs idle and all storage zero after reset
      chk("R1 rd_valid", 32'(rd_valid), 32'd0);
      chk("R1 elem_valid", 32'(elem_valid), 32'd0);
      for (int r = 0; r < N; r++) do_slice(1'b0, r, 1'b1, 1'b0, '0, "R1");

      // R7, R8: element fill then element readback
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) do_elem(1'b1, i, j, pat(1, i, j), 1'b0, "R7");
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) do_elem(1'b0, i, j, '0, 1'b0, "R8");
      // R2, R3, R7: element-written data through both slice orientations
      for (int r = 0; r < N; r++) do_slice(1'b0, r, 1'b1, 1'b0, '0, "R2");
      for (int c = 0; c < N; c++) do_slice(1'b1, c, 1'b1, 1'b0, '0, "R3");

      // R4: row writes, checked by column reads and element reads
      for (int r = 0; r < N; r++) do_slice(1'b0, r, 1'b0, 1'b1, slice_bus(2, 1'b0, r), "R4");
      for (int c = 0; c < N; c++) do_slice(1'b1, c, 1'b1, 1'b0, '0, "R4 R3");
      for (int i = 0; i < N; i++) do_elem(1'b0, i, (i * 3) % N, '0, 1'b0, "R4 R8");

      // R5: column writes, checked by row reads and element reads
      for (int c = 0; c < N; c++) do_slice(1'b1, c, 1'b0, 1'b1, slice_bus(3, 1'b1, c), "R5");
      for (int r = 0; r < N; r++) do_slice(1'b0, r, 1'b1, 1'b0, '0, "R5 R2");
      for (int i = 0; i < N; i++) do_elem(1'b0, (i * 5) % N, i, '0, 1'b0, "R5 R8");

      // R6: read-during-write returns old data, then new data
      for (int r = 0; r < N; r++) begin
         do_slice(1'b0, r, 1'b1, 1'b1, slice_bus(4, 1'b0, r), "R6 row");
         do_slice(1'b0, r, 1'b1, 1'b0, '0, "R6 row after");
      end
      for (int c = 0; c < N; c++) begin
         do_slice(1'b1, c, 1'b1, 1'b1, slice_bus(5, 1'b1, c), "R6 col");
         do_slice(1'b1, c, 1'b1, 1'b0, '0, "R6 col after");
      end

      // R9: element accesses during a slice read are ignored
      for (int j = 0; j < N; j++) begin
         do_elem(1'b1, j, j, 16'hDEAD, 1'b1, "R9 write");
         do_elem(1'b0, j, j, '0, 1'b1, "R9 read");
         do_elem(1'b0, j, j, '0, 1'b0, "R9 unchanged");
      end
      chk("R2 rd_valid low", 32'(rd_valid), 32'd0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule